// File: doc/BRIEF.md
# Four-Phase Handshake Transfer Controller

This block moves one data word at a time from a sender to a receiver that agree on no common timing. The two ends talk over a parallel data bus and two control wires. One wire, `link_valid`, is driven by the sender. The other, `link_ctl`, is driven by the receiver. Every step of the exchange is interlocked, so either end may take as long as it likes at any step. The transfer therefore runs at the pace of the slower end.

The parameter `SRC_INIT` selects which end opens the exchange:

- **Sender-led (`SRC_INIT`=1):** `link_ctl` acts as an acknowledge. The sender presents the word, raises valid, waits for the acknowledge, and drops valid. The receiver then drops the acknowledge.
- **Receiver-led (`SRC_INIT`=0):** `link_ctl` acts as a ready-for-data request. The receiver raises ready. The sender answers with data and valid. The receiver captures the word and drops ready. The sender then drops valid.

Each end has a small local interface: a request, a busy level, a one-cycle done pulse and a sticky error flag. Each control wire entering an end passes through a two-flop synchroniser before that end's state machine uses it.

Each waiting state counts cycles. If the partner has not made its move within `TIMEOUT` cycles, the waiting end raises its error flag, releases its control wire and returns to idle.

Top module: `hs_xfer_top`

## Requirements
- R1: During and right after reset, `link_valid`, `link_ctl`, both busy levels, both done pulses and both error flags are 0.
- R2: In sender-led mode, a word presented on `src_data` while `src_req` is high is delivered unchanged on `dst_data` when `dst_done` pulses. This holds for any data pattern.
- R3: In receiver-led mode, a word is delivered the same way, once the receiver has asked with `dst_req` and the sender has answered with `src_req`.
- R4: `link_valid` rises only when the opposite wire is in its resting state for the mode. That resting state is `link_ctl`=0 in sender-led mode and `link_ctl`=1 in receiver-led mode.
- R5: `link_data` is already stable in the cycle `link_valid` rises, and it holds its value for as long as `link_valid` stays high.
- R6: `src_done` and `dst_done` are each high for exactly one cycle per completed transfer.
- R7: In sender-led mode, if the receiver never accepts (`dst_req` held 0), the sender sets `src_err`, drops `link_valid` and returns to idle within a bounded number of cycles (about `TIMEOUT`). No done pulse is raised.
- R8: Once set, `src_err` and `dst_err` stay 1 until reset. Later transfers still complete correctly.
- R9: In receiver-led mode, if the sender never answers, the receiver sets `dst_err`, drops `link_ctl` and returns to idle.
- R10: In sender-led mode, the receiver does not capture and does not acknowledge while its local `dst_req` is 0, even though `link_valid` is high.
- R11: A partner delay shorter than the timeout, such as `TIMEOUT`/2 cycles, completes without raising an error.
- R12: An end that sits idle, whatever the other end is doing, never raises its error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ends |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | 1 | Sender: a word is waiting to be sent (sampled only while idle) |
| src_data | input | DATA_W | Sender: the word to send |
| src_busy | output | 1 | Sender: a transfer is in progress |
| src_done | output | 1 | Sender: one-cycle pulse when its last phase completes |
| src_err | output | 1 | Sender: sticky timeout flag |
| dst_req | input | 1 | Receiver: willing to take a word (level) |
| dst_data | output | DATA_W | Receiver: last captured word |
| dst_busy | output | 1 | Receiver: a transfer is in progress |
| dst_done | output | 1 | Receiver: one-cycle pulse when its last phase completes |
| dst_err | output | 1 | Receiver: sticky timeout flag |
| link_valid | output | 1 | Link wire driven by the sender |
| link_ctl | output | 1 | Link wire driven by the receiver (acknowledge or ready) |
| link_data | output | DATA_W | Link data bus |

## Verification
The properties assume that local requests reach each end only through its own request inputs. They also assume that the link wires are driven solely by the two ends inside the block, so the partner always follows the protocol order. Under that assumption, the wire ordering and data-stability properties can be checked unconditionally.

The stimulus holds `src_req` only until `src_busy` rises. It drops `dst_req` on the falling edge after `dst_done` or `dst_err` is seen, so a receiver-led end never reopens an exchange by accident.

Timeout cases are produced by withholding one end's local request, never by forcing link wires. Every partner delay used for a successful transfer is kept well below `TIMEOUT`.

// File: rtl/hs_pkg.sv
// Shared state encodings for the two ends of the handshake link.
package hs_pkg;
    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_SETUP   = 2'd1,
        S_VALID   = 2'd2,
        S_RELEASE = 2'd3
    } src_st_e;

    typedef enum logic [1:0] {
        D_IDLE  = 2'd0,
        D_READY = 2'd1,
        D_ACK   = 2'd2,
        D_WAIT  = 2'd3
    } dst_st_e;
endpackage

// File: rtl/hs_sync.sv
// Two-flop synchroniser for WIDTH independent single-bit control wires.
// Assumes each bit is a level that stays put for several cycles; no bus coherence.
module hs_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta;

    // two register stages, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/hs_src.sv
// Sender end of the four-phase link. Loads the word one cycle before raising
// valid, then steps through the phases chosen by SRC_INIT. Assumes ctl_s has
// already been synchronised. Each waiting state is guarded by a cycle limit.
module hs_src
    import hs_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int TIMEOUT  = 256,
    parameter bit SRC_INIT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [DATA_W-1:0] din,
    input  logic              ctl_s,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              valid,
    output logic [DATA_W-1:0] data
);
    localparam int CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
    localparam logic [CNT_W-1:0] LIM = CNT_W'(TIMEOUT - 1);

    src_st_e          state;
    logic [CNT_W-1:0] cnt;
    logic             waiting, go, expire, start;

    // progress condition for the current waiting state
    always_comb begin
        waiting = (state == S_VALID) || (state == S_RELEASE);
        case (state)
            S_VALID:   go = SRC_INIT ? ctl_s : !ctl_s;
            S_RELEASE: go = !ctl_s;
            default:   go = 1'b0;
        endcase
        expire = waiting && !go && (cnt == LIM);
        start  = req && (SRC_INIT || ctl_s);
        busy   = (state != S_IDLE);
    end

    // cycle counter for the waiting states
    always_ff @(posedge clk) begin
        if (!rst_n || !waiting || go || expire) cnt <= '0;
        else                                    cnt <= cnt + 1'b1;
    end

    // phase sequencing, data hold, done pulse and sticky error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            valid <= 1'b0;
            done  <= 1'b0;
            err   <= 1'b0;
            data  <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    data  <= din;
                    state <= S_SETUP;
                end
                S_SETUP: begin
                    valid <= 1'b1;
                    state <= S_VALID;
                end
                S_VALID: if (expire) begin
                    valid <= 1'b0;
                    err   <= 1'b1;
                    state <= S_IDLE;
                end else if (go) begin
                    valid <= 1'b0;
                    if (SRC_INIT) state <= S_RELEASE;
                    else begin
                        done  <= 1'b1;
                        state <= S_IDLE;
                    end
                end
                S_RELEASE: if (expire) begin
                    err   <= 1'b1;
                    state <= S_IDLE;
                end else if (go) begin
                    done  <= 1'b1;
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hs_dst.sv
// Receiver end of the four-phase link. In sender-led mode it acknowledges a
// valid word only while its local request is high; in receiver-led mode it
// raises ready on request. Assumes valid_s is synchronised and that the bus
// was stable before valid was raised. Waiting states are time-limited.
module hs_dst
    import hs_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int TIMEOUT  = 256,
    parameter bit SRC_INIT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              valid_s,
    input  logic [DATA_W-1:0] bus,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              ctl,
    output logic [DATA_W-1:0] data
);
    localparam int CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
    localparam logic [CNT_W-1:0] LIM = CNT_W'(TIMEOUT - 1);

    dst_st_e          state;
    logic [CNT_W-1:0] cnt;
    logic             waiting, go, expire;

    // progress condition for the current waiting state
    always_comb begin
        waiting = (state != D_IDLE);
        go      = (state == D_READY) ? valid_s : !valid_s;
        expire  = waiting && !go && (cnt == LIM);
        busy    = waiting;
    end

    // cycle counter for the waiting states
    always_ff @(posedge clk) begin
        if (!rst_n || !waiting || go || expire) cnt <= '0;
        else                                    cnt <= cnt + 1'b1;
    end

    // phase sequencing, capture, done pulse and sticky error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= D_IDLE;
            ctl   <= 1'b0;
            done  <= 1'b0;
            err   <= 1'b0;
            data  <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                D_IDLE: if (req) begin
                    if (!SRC_INIT) begin
                        ctl   <= 1'b1;
                        state <= D_READY;
                    end else if (valid_s) begin
                        data  <= bus;
                        ctl   <= 1'b1;
                        state <= D_ACK;
                    end
                end
                D_READY: if (expire) begin
                    ctl   <= 1'b0;
                    err   <= 1'b1;
                    state <= D_IDLE;
                end else if (go) begin
                    data  <= bus;
                    ctl   <= 1'b0;
                    state <= D_WAIT;
                end
                D_ACK: if (expire) begin
                    ctl   <= 1'b0;
                    err   <= 1'b1;
                    state <= D_IDLE;
                end else if (go) begin
                    ctl   <= 1'b0;
                    done  <= 1'b1;
                    state <= D_IDLE;
                end
                D_WAIT: if (expire) begin
                    err   <= 1'b1;
                    state <= D_IDLE;
                end else if (go) begin
                    done  <= 1'b1;
                    state <= D_IDLE;
                end
                default: state <= D_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hs_xfer_top.sv
// Both ends of a four-phase handshake link, joined by two control wires and a
// data bus. Each control wire is synchronised on entry to the end that reads it.
// SRC_INIT picks sender-led (1) or receiver-led (0) sequencing.
module hs_xfer_top #(
    parameter int DATA_W   = 8,
    parameter int TIMEOUT  = 256,
    parameter bit SRC_INIT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_req,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_busy,
    output logic              src_done,
    output logic              src_err,
    input  logic              dst_req,
    output logic [DATA_W-1:0] dst_data,
    output logic              dst_busy,
    output logic              dst_done,
    output logic              dst_err,
    output logic              link_valid,
    output logic              link_ctl,
    output logic [DATA_W-1:0] link_data
);
    logic ctl_s, valid_s;

    hs_sync #(.WIDTH(1)) u_sync_ctl (
        .clk(clk), .rst_n(rst_n), .d(link_ctl), .q(ctl_s)
    );

    hs_sync #(.WIDTH(1)) u_sync_valid (
        .clk(clk), .rst_n(rst_n), .d(link_valid), .q(valid_s)
    );

    hs_src #(.DATA_W(DATA_W), .TIMEOUT(TIMEOUT), .SRC_INIT(SRC_INIT)) u_src (
        .clk(clk), .rst_n(rst_n), .req(src_req), .din(src_data),
        .ctl_s(ctl_s), .busy(src_busy), .done(src_done), .err(src_err),
        .valid(link_valid), .data(link_data)
    );

    hs_dst #(.DATA_W(DATA_W), .TIMEOUT(TIMEOUT), .SRC_INIT(SRC_INIT)) u_dst (
        .clk(clk), .rst_n(rst_n), .req(dst_req), .valid_s(valid_s),
        .bus(link_data), .busy(dst_busy), .done(dst_done), .err(dst_err),
        .ctl(link_ctl), .data(dst_data)
    );
endmodule

// File: rtl/hs_xfer_chk.sv
// Protocol checker for hs_xfer_top: wire ordering, data stability, done pulse
// width and error stickiness. Attached through bind below.
module hs_xfer_chk #(
    parameter int DATA_W   = 8,
    parameter bit SRC_INIT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              link_valid,
    input logic              link_ctl,
    input logic [DATA_W-1:0] link_data,
    input logic              src_done,
    input logic              dst_done,
    input logic              src_err,
    input logic              dst_err
);
    // R4: valid rises only when the receiver's wire is at rest for the mode
    p_valid_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_valid) |-> (link_ctl == !SRC_INIT));

    // R5: bus already settled when valid rises
    p_data_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_valid) |-> $stable(link_data));

    // R5: bus held while valid stays high
    p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (link_valid && $past(link_valid)) |-> $stable(link_data));

    // R6: single-cycle done pulses
    p_src_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        src_done |=> !src_done);
    p_dst_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dst_done |=> !dst_done);

    // R8: error flags are sticky
    p_src_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        src_err |=> src_err);
    p_dst_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dst_err |=> dst_err);
endmodule

bind hs_xfer_top hs_xfer_chk #(.DATA_W(DATA_W), .SRC_INIT(SRC_INIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .link_valid(link_valid), .link_ctl(link_ctl),
    .link_data(link_data), .src_done(src_done), .dst_done(dst_done),
    .src_err(src_err), .dst_err(dst_err)
);

// File: tb/tb_hs_xfer_top.sv
// Scoreboard bench: dut runs sender-led, dut_d runs receiver-led.
module tb_hs_xfer_top;
    localparam int DW = 8;
    localparam int TO = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    // sender-led instance
    logic          s_sreq = 0, s_dreq = 0;
    logic [DW-1:0] s_sdat = '0;
    logic          s_sbusy, s_sdone, s_serr, s_dbusy, s_ddone, s_derr, s_lv, s_lc;
    logic [DW-1:0] s_ddat, s_ldat;

    // receiver-led instance
    logic          d_sreq = 0, d_dreq = 0;
    logic [DW-1:0] d_sdat = '0;
    logic          d_sbusy, d_sdone, d_serr, d_dbusy, d_ddone, d_derr, d_lv, d_lc;
    logic [DW-1:0] d_ddat, d_ldat;

    hs_xfer_top #(.DATA_W(DW), .TIMEOUT(TO), .SRC_INIT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .src_req(s_sreq), .src_data(s_sdat),
        .src_busy(s_sbusy), .src_done(s_sdone), .src_err(s_serr),
        .dst_req(s_dreq), .dst_data(s_ddat), .dst_busy(s_dbusy),
        .dst_done(s_ddone), .dst_err(s_derr), .link_valid(s_lv),
        .link_ctl(s_lc), .link_data(s_ldat)
    );

    hs_xfer_top #(.DATA_W(DW), .TIMEOUT(TO), .SRC_INIT(1'b0)) dut_d (
        .clk(clk), .rst_n(rst_n), .src_req(d_sreq), .src_data(d_sdat),
        .src_busy(d_sbusy), .src_done(d_sdone), .src_err(d_serr),
        .dst_req(d_dreq), .dst_data(d_ddat), .dst_busy(d_dbusy),
        .dst_done(d_ddone), .dst_err(d_derr), .link_valid(d_lv),
        .link_ctl(d_lc), .link_data(d_ldat)
    );

    int checks = 0, fails = 0;
    logic [DW-1:0] q_s[$], q_d[$];
    int sdone_s = 0, ddone_s = 0, sdone_d = 0, ddone_d = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // monitors: pop expected words on each receiver done pulse (R2, R3, R6)
    always @(negedge clk) if (rst_n) begin
        if (s_sdone) sdone_s++;
        if (d_sdone) sdone_d++;
        if (s_ddone) begin
            ddone_s++;
            if (q_s.size() == 0) chk(0, "R2 unexpected delivery", s_ddat, 0);
            else begin
                logic [DW-1:0] e;
                e = q_s.pop_front();
                chk(s_ddat == e, "R2 data", s_ddat, e);
            end
        end
        if (d_ddone) begin
            ddone_d++;
            if (q_d.size() == 0) chk(0, "R3 unexpected delivery", d_ddat, 0);
            else begin
                logic [DW-1:0] e;
                e = q_d.pop_front();
                chk(d_ddat == e, "R3 data", d_ddat, e);
            end
        end
    end

    // sender-led transfer with receiver delay (cycles)
    task automatic xfer_s(input logic [DW-1:0] w, input int dly);
        int s0, d0;
        s0 = sdone_s; d0 = ddone_s;
        q_s.push_back(w);
        @(negedge clk);
        s_sdat = w; s_sreq = 1;
        for (int i = 0; i < 10 && !s_sbusy; i++) @(negedge clk);
        s_sreq = 0;
        repeat (dly) @(negedge clk);
        s_dreq = 1;
        for (int i = 0; i < 4*TO && !s_ddone; i++) @(negedge clk);
        s_dreq = 0;
        for (int i = 0; i < 4*TO && (s_sbusy || s_dbusy); i++) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(ddone_s == d0 + 1, "R6 dst done count", ddone_s - d0, 1);
        chk(sdone_s == s0 + 1, "R6 src done count", sdone_s - s0, 1);
    endtask

    // receiver-led transfer with sender delay (cycles)
    task automatic xfer_d(input logic [DW-1:0] w, input int dly);
        int s0, d0;
        s0 = sdone_d; d0 = ddone_d;
        q_d.push_back(w);
        @(negedge clk);
        d_dreq = 1;
        repeat (dly) @(negedge clk);
        d_sdat = w; d_sreq = 1;
        for (int i = 0; i < 4*TO && !d_sbusy; i++) @(negedge clk);
        d_sreq = 0;
        for (int i = 0; i < 4*TO && !d_ddone; i++) @(negedge clk);
        d_dreq = 0;
        for (int i = 0; i < 4*TO && (d_sbusy || d_dbusy); i++) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(ddone_d == d0 + 1, "R6 dst done count (rx-led)", ddone_d - d0, 1);
        chk(sdone_d == s0 + 1, "R6 src done count (rx-led)", sdone_d - s0, 1);
    endtask

    initial begin
        #200000;
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({s_lv, s_lc, s_sbusy, s_dbusy, s_sdone, s_ddone, s_serr, s_derr} == 0,
            "R1 reset sender-led", {s_lv, s_lc, s_sbusy, s_dbusy, s_serr, s_derr}, 0);
        chk({d_lv, d_lc, d_sbusy, d_dbusy, d_sdone, d_ddone, d_serr, d_derr} == 0,
            "R1 reset rx-led", {d_lv, d_lc, d_sbusy, d_dbusy, d_serr, d_derr}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(s_lv == 0 && s_lc == 0 && d_lc == 0, "R1 after reset", s_lv, 0);

        // R2: sender-led patterns
        xfer_s(8'hA5, 0);
        xfer_s(8'h00, 3);
        xfer_s(8'hFF, 1);
        xfer_s(8'h5A, 0);
        // R11: slow receiver within the limit
        xfer_s(8'h3C, TO/2);
        chk(s_serr == 0 && s_derr == 0, "R11 no error on slow receiver", s_serr, 0);

        // R3: receiver-led patterns
        xfer_d(8'h96, 0);
        xfer_d(8'h01, 4);
        xfer_d(8'hFE, 0);
        // R11: slow sender within the limit
        xfer_d(8'hC3, TO/2);
        chk(d_serr == 0 && d_derr == 0, "R11 no error on slow sender", d_derr, 0);

        // R7 / R10: receiver never accepts
        begin
            int s0, d0;
            s0 = sdone_s; d0 = ddone_s;
            @(negedge clk);
            s_sdat = 8'h77; s_sreq = 1;
            for (int i = 0; i < 10 && !s_sbusy; i++) @(negedge clk);
            s_sreq = 0;
            repeat (TO/2) @(negedge clk);
            chk(s_lv == 1 && s_lc == 0, "R10 no ack without dst_req", s_lc, 0);
            for (int i = 0; i < 4*TO && s_sbusy; i++) @(negedge clk);
            chk(s_serr == 1, "R7 src timeout flag", s_serr, 1);
            chk(s_lv == 0 && s_sbusy == 0, "R7 valid released", s_lv, 0);
            repeat (4) @(negedge clk);
            chk(sdone_s == s0 && ddone_s == d0, "R7 no done on timeout", sdone_s - s0, 0);
            chk(s_derr == 0, "R12 idle receiver no error", s_derr, 0);
        end
        // R8: sticky, and link still usable
        xfer_s(8'h42, 2);
        chk(s_serr == 1, "R8 src_err sticky", s_serr, 1);

        // R9: sender never answers in receiver-led mode
        @(negedge clk);
        d_dreq = 1;
        for (int i = 0; i < 4*TO && !d_derr; i++) @(negedge clk);
        d_dreq = 0;
        chk(d_derr == 1, "R9 dst timeout flag", d_derr, 1);
        chk(d_lc == 0, "R9 ready released", d_lc, 0);
        @(negedge clk);
        chk(d_dbusy == 0, "R9 receiver idle", d_dbusy, 0);
        chk(d_serr == 0, "R12 idle sender no error", d_serr, 0);
        xfer_d(8'h24, 1);
        chk(d_derr == 1, "R8 dst_err sticky", d_derr, 1);

        chk(q_s.size() == 0 && q_d.size() == 0, "R2 R3 all words delivered",
            q_s.size() + q_d.size(), 0);
        finish_run();
    end
endmodule